// File: doc/BRIEF.md
# DMA Start and Completion Signalling Controller

This block decides when each of a small group of DMA channels (five by default) may start, and records when each one finishes. Every channel has a small configuration register. It holds a five-bit source code that selects what starts the channel, and an interrupt-mask bit. A source can be a one-shot software request, the finish of the channel numbered one below, an edge on one of two pin inputs, or one of a fixed set of peripheral event pulses. The controller turns the selected source into a single-cycle start pulse that goes to the transfer engine.

The transfer engine reports back with one finish pulse per channel. On each finish the block sets that channel's completion flag, whatever the channel's mask bit says. If the mask bit is set, the finish also raises a shared DMA interrupt flag. That flag reaches the CPU as an interrupt request only while a global enable bit is set.

Software reaches the block through a simple register port: a write strobe with address and data, and a combinational read path. The address map is: channel configuration registers at addresses 0 to 4, the request register at 5, the completion status at 6 and the control register at 7.

Top module: `dma_trig_ctrl`

## Requirements
- R1: Source code 0 selects the software request. Writing 1 to bit c of the request register (address 5) gives exactly one pulse on trig_out[c], two cycles after the write strobe is sampled. The request bit clears by itself and reads back as 0. A request for a channel whose code is not 0 is dropped and gives no pulse.
- R2: Source code 1 chains channel c to the finish of channel c-1. Channel 0 takes channel 4 (the last) as its predecessor. trig_out[c] pulses in the cycle after ch_done of the predecessor.
- R3: Source codes 2-4, 6-11 and 14-21 select periph_evt[code]. A pulse on that input gives trig_out[c] in the next cycle. Pulses on other event inputs do nothing.
- R4: Code 12 fires on a rising edge of pin_rise_in, and code 13 fires on a falling edge of pin_fall_in. A level that is held, and the opposite edge, give no pulse.
- R5: Code 5 and codes 22 to 31 never give a start pulse, even when every event input is high.
- R6: A ch_done[c] pulse sets bit c of the status register (address 6) in the next cycle, even when the channel's mask bit (configuration bit 5) is 0.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it. A finish in the same cycle as the clear wins, so the bit stays set.
- R8: A finish on a channel whose mask bit is 1 sets the shared flag (control bit 1). The flag stays set until 1 is written to control bit 1. A finish in the same cycle as that clear wins. Finishes on channels whose mask bit is 0 never set the flag.
- R9: cpu_irq is high exactly while the shared flag is set and the global enable (control bit 0) is 1.
- R10: After reset all codes, masks, requests, status bits, the enable and the shared flag are 0, and trig_out and cpu_irq are low.
- R11: The configuration register holds the code in bits 4:0 and the mask in bit 5. It reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 6 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 6 | Combinational read data |
| periph_evt | input | 32 | Peripheral event pulses, indexed by source code |
| pin_rise_in | input | 1 | Pin whose rising edge is source 12 |
| pin_fall_in | input | 1 | Pin whose falling edge is source 13 |
| ch_done | input | 5 | Per-channel finish pulses from the transfer engine |
| trig_out | output | 5 | Per-channel start pulses |
| cpu_irq | output | 1 | Gated CPU interrupt request |

## Verification
A finish reported by the transfer engine can land in the same cycle as a software write that clears the same status bit or the shared flag. The bench forces this collision by raising ch_done and a write-one-to-clear of that bit on one clock edge. It then reads the status and control registers. The colliding bit must still be set, and a neighbouring bit that was cleared alone must be gone. The random phase adds many more finish-versus-start overlaps, such as chained starts and peripheral starts on the same edge. Each one is judged against a bench model of start pulses and flags.

// File: rtl/dma_trig_pkg.sv
// Shared constants and helpers for the DMA start/finish controller.
// Assumes a five-bit source code; the source map is fixed by the spec.
package dma_trig_pkg;
    localparam int CODE_W    = 5;
    localparam int NUM_CODES = 1 << CODE_W;

    localparam logic [CODE_W-1:0] SRC_SOFT     = 5'd0;
    localparam logic [CODE_W-1:0] SRC_CHAIN    = 5'd1;
    localparam logic [CODE_W-1:0] SRC_GAP      = 5'd5;
    localparam logic [CODE_W-1:0] SRC_PIN_UP   = 5'd12;
    localparam logic [CODE_W-1:0] SRC_PIN_DOWN = 5'd13;
    localparam logic [CODE_W-1:0] SRC_LAST     = 5'd21;

    // True when the code selects a plain peripheral event pulse.
    function automatic logic src_is_periph(input logic [CODE_W-1:0] c);
        return (c > SRC_CHAIN) && (c <= SRC_LAST) && (c != SRC_GAP)
            && (c != SRC_PIN_UP) && (c != SRC_PIN_DOWN);
    endfunction

    // True when the code never starts a channel.
    function automatic logic src_is_dead(input logic [CODE_W-1:0] c);
        return (c == SRC_GAP) || (c > SRC_LAST);
    endfunction
endpackage

// File: rtl/dma_trig_regs.sv
// Register file: per-channel configuration, one-shot request bits,
// global enable, and the write-one-to-clear strobes for the status logic.
// Assumes DATA_W covers both the channel count and CODE_W+1 bits.
module dma_trig_regs
    import dma_trig_pkg::*;
#(
    parameter int NCH    = 5,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NCH-1:0][CODE_W-1:0]    cfg_code,
    output logic [NCH-1:0]                cfg_mask,
    output logic [NCH-1:0]                sw_req,
    output logic                          glb_en,
    output logic [NCH-1:0]                clr_status,
    output logic                          clr_shared
);
    localparam int A_REQ  = NCH;
    localparam int A_STAT = NCH + 1;
    localparam int A_CTRL = NCH + 2;

    logic           wr_req, wr_stat, wr_ctrl;
    logic [NCH-1:0] req_set;

    // Decode which shared register the current write targets.
    always_comb begin
        wr_req     = wr_en && (wr_addr == ADDR_W'(A_REQ));
        wr_stat    = wr_en && (wr_addr == ADDR_W'(A_STAT));
        wr_ctrl    = wr_en && (wr_addr == ADDR_W'(A_CTRL));
        req_set    = wr_req  ? wr_data[NCH-1:0] : '0;
        clr_status = wr_stat ? wr_data[NCH-1:0] : '0;
        clr_shared = wr_ctrl && wr_data[1];
    end

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_cfg
            // Hold the source code and mask bit of one channel.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_code[c] <= '0;
                    cfg_mask[c] <= 1'b0;
                end else if (wr_en && (wr_addr == ADDR_W'(c))) begin
                    cfg_code[c] <= wr_data[CODE_W-1:0];
                    cfg_mask[c] <= wr_data[CODE_W];
                end
            end
        end
    endgenerate

    // Request bits live for one cycle: set by a write, gone on the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_req <= '0;
        else        sw_req <= req_set;
    end

    // Global interrupt enable in control bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)       glb_en <= 1'b0;
        else if (wr_ctrl) glb_en <= wr_data[0];
    end
endmodule

// File: rtl/dma_trig_select.sv
// Per-channel source selection and start-pulse register.
// Assumes peripheral inputs are single-cycle pulses; pin inputs are
// synchronous levels whose edges are found here.
module dma_trig_select
    import dma_trig_pkg::*;
#(
    parameter int NCH = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0][CODE_W-1:0] cfg_code,
    input  logic [NCH-1:0]             sw_req,
    input  logic [NUM_CODES-1:0]       periph_evt,
    input  logic                       pin_rise_in,
    input  logic                       pin_fall_in,
    input  logic [NCH-1:0]             ch_done,
    output logic [NCH-1:0]             trig_q
);
    logic rise_prev, fall_prev;
    logic pin_up, pin_down;

    // Remember the pin levels of the last cycle; in reset track them so
    // that no false edge appears when reset is released.
    always_ff @(posedge clk) begin
        rise_prev <= pin_rise_in;
        fall_prev <= pin_fall_in;
    end

    // Edge detection for the two pin sources.
    always_comb begin
        pin_up   = pin_rise_in & ~rise_prev;
        pin_down = ~pin_fall_in & fall_prev;
    end

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            localparam int PREV = (c == 0) ? NCH - 1 : c - 1;
            logic hit;

            // Pick the event that the channel's code selects.
            always_comb begin
                if (cfg_code[c] == SRC_SOFT)          hit = sw_req[c];
                else if (cfg_code[c] == SRC_CHAIN)    hit = ch_done[PREV];
                else if (cfg_code[c] == SRC_PIN_UP)   hit = pin_up;
                else if (cfg_code[c] == SRC_PIN_DOWN) hit = pin_down;
                else if (src_is_periph(cfg_code[c]))  hit = periph_evt[cfg_code[c]];
                else                                  hit = 1'b0;
            end

            // Register the start pulse for the transfer engine.
            always_ff @(posedge clk) begin
                if (!rst_n) trig_q[c] <= 1'b0;
                else        trig_q[c] <= hit;
            end

            assert_soft_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_code[c] == SRC_SOFT && sw_req[c]) |=> trig_q[c]);
            assert_chain_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_code[c] == SRC_CHAIN && ch_done[PREV]) |=> trig_q[c]);
            assert_periph_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (src_is_periph(cfg_code[c]) && periph_evt[cfg_code[c]]) |=> trig_q[c]);
            assert_dead_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
                src_is_dead(cfg_code[c]) |=> !trig_q[c]);
        end
    endgenerate
endmodule

// File: rtl/dma_trig_status.sv
// Completion flags per channel and the shared interrupt flag.
// Assumes clears arrive as write-one strobes; a finish beats a clear.
module dma_trig_status #(
    parameter int NCH = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ch_done,
    input  logic [NCH-1:0] cfg_mask,
    input  logic [NCH-1:0] clr_status,
    input  logic           clr_shared,
    output logic [NCH-1:0] done_flags,
    output logic           shared_flag
);
    logic masked_done;

    // Any finish that is allowed to raise the shared flag.
    always_comb masked_done = |(ch_done & cfg_mask);

    // Per-channel flags: clear on write-one, set on finish (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) done_flags <= '0;
        else        done_flags <= (done_flags & ~clr_status) | ch_done;
    end

    // Shared flag: sticky until cleared, a masked finish wins the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          shared_flag <= 1'b0;
        else if (masked_done) shared_flag <= 1'b1;
        else if (clr_shared)  shared_flag <= 1'b0;
    end

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_chk
            assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
                ch_done[c] |=> done_flags[c]);
            assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (done_flags[c] && !clr_status[c]) |=> done_flags[c]);
        end
    endgenerate

    assert_shared_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (shared_flag && !clr_shared) |=> shared_flag);
    assert_shared_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!shared_flag && !(|(ch_done & cfg_mask))) |=> !shared_flag);
endmodule

// File: rtl/dma_trig_ctrl.sv
// Top of the DMA start/finish controller: registers, source selection,
// completion flags, read mux and the gated CPU request.
// Assumes NCH fits in the data word and the address space holds NCH+3 words.
module dma_trig_ctrl
    import dma_trig_pkg::*;
#(
    parameter int NCH    = 5,
    parameter int ADDR_W = $clog2(NCH + 3),
    parameter int DATA_W = (NCH > CODE_W + 1) ? NCH : CODE_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    input  logic [NUM_CODES-1:0] periph_evt,
    input  logic                 pin_rise_in,
    input  logic                 pin_fall_in,
    input  logic [NCH-1:0]       ch_done,
    output logic [NCH-1:0]       trig_out,
    output logic                 cpu_irq
);
    localparam int A_REQ  = NCH;
    localparam int A_STAT = NCH + 1;
    localparam int A_CTRL = NCH + 2;

    logic [NCH-1:0][CODE_W-1:0] cfg_code;
    logic [NCH-1:0]             cfg_mask;
    logic [NCH-1:0]             sw_req;
    logic                       glb_en;
    logic [NCH-1:0]             clr_status;
    logic                       clr_shared;
    logic [NCH-1:0]             done_flags;
    logic                       shared_flag;

    dma_trig_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cfg_code   (cfg_code),
        .cfg_mask   (cfg_mask),
        .sw_req     (sw_req),
        .glb_en     (glb_en),
        .clr_status (clr_status),
        .clr_shared (clr_shared)
    );

    dma_trig_select #(.NCH(NCH)) u_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_code    (cfg_code),
        .sw_req      (sw_req),
        .periph_evt  (periph_evt),
        .pin_rise_in (pin_rise_in),
        .pin_fall_in (pin_fall_in),
        .ch_done     (ch_done),
        .trig_q      (trig_out)
    );

    dma_trig_status #(.NCH(NCH)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .ch_done     (ch_done),
        .cfg_mask    (cfg_mask),
        .clr_status  (clr_status),
        .clr_shared  (clr_shared),
        .done_flags  (done_flags),
        .shared_flag (shared_flag)
    );

    // Gate the shared flag with the global enable toward the CPU.
    always_comb cpu_irq = shared_flag & glb_en;

    // Read mux over configuration, request, status and control words.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = DATA_W'({cfg_mask[i], cfg_code[i]});
        end
        if (rd_addr == ADDR_W'(A_REQ))  rd_data = DATA_W'(sw_req);
        if (rd_addr == ADDR_W'(A_STAT)) rd_data = DATA_W'(done_flags);
        if (rd_addr == ADDR_W'(A_CTRL)) rd_data = DATA_W'({shared_flag, glb_en});
    end

    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && !(wr_en && wr_addr == ADDR_W'(A_CTRL))) |=> !cpu_irq);
endmodule

// File: tb/dma_trig_ctrl_bench.sv
module dma_trig_ctrl_bench;
    localparam int NCH = 5;
    localparam logic [2:0] A_REQ = 3'd5, A_STAT = 3'd6, A_CTRL = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr, rd_addr;
    logic [5:0]  wr_data, rd_data;
    logic [31:0] periph_evt;
    logic        pin_rise_in, pin_fall_in;
    logic [4:0]  ch_done, trig_out;
    logic        cpu_irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dma_trig_ctrl u_dma_trig_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .periph_evt(periph_evt), .pin_rise_in(pin_rise_in),
        .pin_fall_in(pin_fall_in), .ch_done(ch_done),
        .trig_out(trig_out), .cpu_irq(cpu_irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [5:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [2:0] a, input logic [5:0] exp);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic pulse_done(input logic [4:0] d);
        @(negedge clk); ch_done = d;
        @(negedge clk); ch_done = '0;
    endtask

    task automatic pulse_evt(input logic [31:0] e);
        @(negedge clk); periph_evt = e;
        @(negedge clk); periph_evt = '0;
    endtask

    // Expected start for one channel given this cycle's inputs.
    function automatic logic model_hit(input int code, input logic [31:0] evt,
                                       input logic up, input logic down,
                                       input logic prev_done, input logic req);
        if (code == 0)  return req;
        if (code == 1)  return prev_done;
        if (code == 12) return up;
        if (code == 13) return down;
        if (code == 5 || code > 21) return 1'b0;
        return evt[code];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd2024);
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        periph_evt = '0; pin_rise_in = 1'b0; pin_fall_in = 1'b1; ch_done = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10 trig_out", trig_out, 0);
        check("R10 cpu_irq", cpu_irq, 0);
        read_check("R10 status", A_STAT, 0);
        read_check("R10 ctrl", A_CTRL, 0);
        read_check("R10 cfg0", 3'd0, 0);

        // R1 software start on channel 2 (code 0 after reset)
        do_write(A_REQ, 6'b000100);
        check("R1 no pulse yet", trig_out, 0);
        @(negedge clk);
        check("R1 pulse", trig_out, 5'b00100);
        read_check("R1 self clear", A_REQ, 0);
        @(negedge clk);
        check("R1 single pulse", trig_out, 0);
        // R1 request dropped when code is not 0; R11 readback
        do_write(3'd1, {1'b0, 5'd3});
        read_check("R11 cfg readback", 3'd1, 6'd3);
        do_write(A_REQ, 6'b000010);
        check("R1 dropped a", trig_out, 0);
        @(negedge clk);
        check("R1 dropped b", trig_out, 0);

        // R2 chaining with wrap from the last channel
        do_write(3'd0, 6'd1);
        do_write(3'd3, 6'd1);
        pulse_done(5'b10000);
        check("R2 wrap to ch0", trig_out, 5'b00001);
        pulse_done(5'b00100);
        check("R2 ch2 to ch3", trig_out, 5'b01000);
        pulse_done(5'b00001);
        check("R2 no chain on ch1", trig_out, 0);

        // R3 peripheral events
        do_write(3'd4, 6'd17);
        pulse_evt(32'h1 << 17);
        check("R3 evt17", trig_out, 5'b10000);
        pulse_evt(32'h1 << 3);
        check("R3 evt3", trig_out, 5'b00010);
        pulse_evt(32'h1 << 16);
        check("R3 unselected evt", trig_out, 0);

        // R4 pin edges
        do_write(3'd2, 6'd12);
        do_write(3'd3, 6'd13);
        pin_rise_in = 1'b1;
        @(negedge clk); check("R4 rising edge", trig_out, 5'b00100);
        @(negedge clk); check("R4 high level", trig_out, 0);
        pin_rise_in = 1'b0;
        @(negedge clk); check("R4 wrong edge up", trig_out, 0);
        pin_fall_in = 1'b0;
        @(negedge clk); check("R4 falling edge", trig_out, 5'b01000);
        @(negedge clk); check("R4 low level", trig_out, 0);
        pin_fall_in = 1'b1;
        @(negedge clk); check("R4 wrong edge down", trig_out, 0);

        // R5 dead codes
        do_write(3'd0, 6'd5);
        do_write(3'd1, 6'd25);
        pulse_evt(32'hFFFF_FFFF);
        check("R5 dead codes", trig_out & 5'b00011, 0);

        // R6 flags regardless of mask
        do_write(A_STAT, 6'h1F);
        read_check("R7 clear all", A_STAT, 0);
        pulse_done(5'b00010);
        read_check("R6 flag unmasked", A_STAT, 6'b000010);
        read_check("R8 no shared unmasked", A_CTRL, 0);

        // R8/R9 shared flag and gate
        do_write(3'd0, {1'b1, 5'd5});
        do_write(A_CTRL, 6'd1);
        pulse_done(5'b00001);
        read_check("R8 shared set", A_CTRL, 6'b11);
        check("R9 irq on", cpu_irq, 1);
        repeat (3) @(negedge clk);
        check("R8 sticky", cpu_irq, 1);
        do_write(A_CTRL, 6'd3);
        read_check("R8 cleared", A_CTRL, 6'b01);
        check("R9 irq off", cpu_irq, 0);
        do_write(A_CTRL, 6'd0);
        pulse_done(5'b00001);
        read_check("R8 set disabled", A_CTRL, 6'b10);
        check("R9 gated", cpu_irq, 0);

        // R7 finish colliding with status clear
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_STAT; wr_data = 6'b000011; ch_done = 5'b00001;
        @(negedge clk);
        wr_en = 1'b0; ch_done = '0;
        read_check("R7 set wins", A_STAT, 6'b000001);
        // R8 finish colliding with shared clear
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_CTRL; wr_data = 6'b000010; ch_done = 5'b00001;
        @(negedge clk);
        wr_en = 1'b0; ch_done = '0;
        read_check("R8 set wins", A_CTRL, 6'b10);
        do_write(A_CTRL, 6'b10);
        read_check("R8 clear alone", A_CTRL, 0);

        // Random phase over R2 R3 R4 R5 R6 R8 R9
        for (int round = 0; round < 6; round++) begin
            logic [4:0] codes [NCH];
            logic [4:0] masks;
            logic [4:0] exp_done;
            logic       exp_sh;
            logic       up_prev, down_prev;
            masks = 5'($urandom);
            for (int c = 0; c < NCH; c++) begin
                codes[c] = 5'($urandom);
                if (codes[c] == 0) codes[c] = 5'd1;
                do_write(3'(c), {masks[c], codes[c]});
            end
            do_write(A_STAT, 6'h1F);
            do_write(A_CTRL, 6'd3);
            exp_done = '0; exp_sh = 1'b0;
            up_prev = pin_rise_in; down_prev = pin_fall_in;
            rd_addr = A_STAT;
            for (int cyc = 0; cyc < 30; cyc++) begin
                logic [4:0] exp_trig;
                logic       up, down;
                periph_evt  = $urandom;
                pin_rise_in = 1'($urandom);
                pin_fall_in = 1'($urandom);
                ch_done     = 5'($urandom);
                up   = pin_rise_in & ~up_prev;
                down = ~pin_fall_in & down_prev;
                for (int c = 0; c < NCH; c++)
                    exp_trig[c] = model_hit(int'(codes[c]), periph_evt, up, down,
                                            ch_done[(c + NCH - 1) % NCH], 1'b0);
                exp_done = exp_done | ch_done;
                exp_sh   = exp_sh | (|(ch_done & masks));
                up_prev = pin_rise_in; down_prev = pin_fall_in;
                @(negedge clk);
                check("R3 random trig", trig_out, exp_trig);
                check("R6 random flags", rd_data, {1'b0, exp_done});
                check("R9 random irq", cpu_irq, exp_sh);
            end
            periph_evt = '0; ch_done = '0;
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule